// File: doc/BRIEF.md
# Serial Register Slave with Interleaved Wide Words

This block is a serial register slave for a four-wire bus: an active-low select, a serial clock, a data input and a data output. The master opens each frame with a command byte that carries a write flag and a 7-bit register address. Data bytes follow. Their count depends on the register addressed: one byte for a byte-wide register and two bytes for a word-wide register. A word-wide register is not sent high byte first. Its bits alternate between the high byte and the low byte, starting from the top bit of each.

The block runs on a system clock that is much faster than the serial clock. The select, clock and data pins pass through a short synchronizer, and every rising edge of the serial clock is turned into a single-cycle strobe. The register file, the table that sets each register's width and the shift logic all sit inside the block. The serial output is a data bit plus an output-enable, so an I/O pad can tristate it. The serial pins are plain pins with no valid/ready handshake, because the bus has no back-pressure: the master owns the clock and the slave follows every edge it sends.

Top module: `spi_ilv_regslave`

## Requirements
- R1: Bit 7 of the command byte is the access flag (1 = write, 0 = read), and bits 6..0 are the address. All fields are sent MSB first, and the input is captured on each rising serial clock edge.
- R2: During the command byte, each received bit appears on the data output after the rising edge that captured it.
- R3: A byte-wide register takes one data byte, MSB first. On a read, data bit k of the value (counting from the MSB) appears after the edge that captures the (k+1)-th data-phase bit.
- R4: A word-wide register takes 16 data bits in the order D15, D7, D14, D6, D13, D5, D12, D4, D11, D3, D10, D2, D9, D1, D8, D0, on both reads and writes. With the default parameters, addresses 1, 3, 5 and 7 are word-wide, and addresses 0, 2, 4 and 6 are byte-wide.
- R5: A write updates the register only on the edge that captures its last data bit. If the select rises before that edge, the register keeps its old value.
- R6: An address with no register (address 8 and above by default) reads as zero, ignores writes and is framed as byte-wide.
- R7: The output-enable is low while the select is high and high while the select is low.
- R8: After reset, every register reads zero.
- R9: Bits clocked in after the frame's last data bit are ignored. During those bits, and during the data phase of a write, the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High when the data output should be driven |

## Verification
The hardest cases to reach from the pins are the frame boundaries: a word write cut off a few bits before its last data bit, and extra clock edges sent after a frame has ended. Both depend on the data-phase length that was latched from the width table, not on anything visible on the bus. The driver therefore takes an explicit bit count for each frame. It releases the select early on a word-wide register, and it over-clocks byte-wide frames with ones on the input. Each case is followed by a read-back that shows whether the stored value changed.

// File: rtl/spi_ilv_pkg.sv
package spi_ilv_pkg;
  localparam int ADDR_W      = 7;
  localparam int CMD_BITS    = 8;
  localparam int BYTE_W      = 8;
  localparam int REG_W       = 16;
  localparam int CNT_W       = $clog2(CMD_BITS + REG_W + 1);
  localparam int NARROW_LAST = CMD_BITS + BYTE_W - 1;
  localparam int WIDE_LAST   = CMD_BITS + REG_W - 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi_ilv_sync.sv
module spi_ilv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mo_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      mo_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck};
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      mo_p  <= {mo_p[STAGES-2:0], mosi};
    end
  end

  // edge strobe and data share the same synchronizer depth
  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign cs_act   = ~cs_p[STAGES-1];
  assign mosi_s   = mo_p[STAGES-1];
endmodule

// File: rtl/spi_ilv_regfile.sv
module spi_ilv_regfile
  import spi_ilv_pkg::*;
#(
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] WIDE_MASK = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_wide
);
  logic [NUM_REGS-1:0][REG_W-1:0] view;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int W = WIDE_MASK[g] ? REG_W : BYTE_W;
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        q <= wr_data[W-1:0];
    end

    assign view[g] = REG_W'(q);
  end

  // unmapped addresses fall through to zero, byte framing
  always_comb begin
    rd_data = '0;
    rd_wide = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data = view[i];
        rd_wide = WIDE_MASK[i];
      end
    end
  end
endmodule

// File: rtl/spi_ilv_shift.sv
module spi_ilv_shift
  import spi_ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic [REG_W-1:0]  rd_data,
  input  logic              rd_wide,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_data,
  output logic              miso,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [CNT_W-1:0]  frame_last
);
  logic [CMD_BITS-2:0] cmd_sr;
  cmd_t                cmd_q;
  logic                wide_q;
  logic [BYTE_W-1:0]   hi_sh;
  logic [BYTE_W-1:0]   lo_sh;
  logic                in_cmd;
  logic                in_data;
  logic [CNT_W-1:0]    data_idx;
  logic                hi_slot;

  assign frame_last = wide_q ? CNT_W'(WIDE_LAST) : CNT_W'(NARROW_LAST);
  assign in_cmd     = bit_cnt < CNT_W'(CMD_BITS);
  assign in_data    = !in_cmd && bit_cnt <= frame_last;
  assign data_idx   = bit_cnt - CNT_W'(CMD_BITS);
  // word registers alternate: even data slots high byte, odd slots low byte
  assign hi_slot    = wide_q && !data_idx[0];

  // address is complete only on the last command edge
  assign rd_addr = {cmd_sr[CMD_BITS-3:0], mosi_s};
  assign wr_addr = cmd_q.addr;
  assign wr_en   = sck_rise && cs_act && cmd_q.wr && in_data && bit_cnt == frame_last;
  assign wr_data = wide_q ? {hi_sh, lo_sh[BYTE_W-2:0], mosi_s}
                          : {{BYTE_W{1'b0}}, lo_sh[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cmd_sr  <= '0;
      cmd_q   <= '0;
      wide_q  <= 1'b0;
      hi_sh   <= '0;
      lo_sh   <= '0;
      miso    <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      miso    <= 1'b0;
    end else if (sck_rise) begin
      if (in_cmd || in_data)
        bit_cnt <= bit_cnt + 1'b1;
      if (in_cmd) begin
        cmd_sr <= {cmd_sr[CMD_BITS-3:0], mosi_s};
        miso   <= mosi_s;
        if (bit_cnt == CNT_W'(CMD_BITS - 1)) begin
          cmd_q  <= '{wr: cmd_sr[CMD_BITS-2], addr: rd_addr};
          wide_q <= rd_wide;
          hi_sh  <= rd_data[REG_W-1:BYTE_W];
          lo_sh  <= rd_data[BYTE_W-1:0];
        end
      end else if (in_data) begin
        if (cmd_q.wr) begin
          miso <= 1'b0;
          if (hi_slot) hi_sh <= {hi_sh[BYTE_W-2:0], mosi_s};
          else         lo_sh <= {lo_sh[BYTE_W-2:0], mosi_s};
        end else if (hi_slot) begin
          miso  <= hi_sh[BYTE_W-1];
          hi_sh <= {hi_sh[BYTE_W-2:0], 1'b0};
        end else begin
          miso  <= lo_sh[BYTE_W-1];
          lo_sh <= {lo_sh[BYTE_W-2:0], 1'b0};
        end
      end else begin
        miso <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_ilv_regslave.sv
module spi_ilv_regslave
  import spi_ilv_pkg::*;
#(
  parameter int                  NUM_REGS    = 8,
  parameter logic [NUM_REGS-1:0] WIDE_MASK   = 8'hAA,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic              sck_rise;
  logic              cs_act;
  logic              mosi_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_en;
  logic [REG_W-1:0]  wr_data;
  logic [REG_W-1:0]  rd_data;
  logic              rd_wide;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  frame_last;

  spi_ilv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .cs_act   (cs_act),
    .mosi_s   (mosi_s)
  );

  spi_ilv_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .cs_act     (cs_act),
    .mosi_s     (mosi_s),
    .rd_data    (rd_data),
    .rd_wide    (rd_wide),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .miso       (spi_miso),
    .bit_cnt    (bit_cnt),
    .frame_last (frame_last)
  );

  spi_ilv_regfile #(.NUM_REGS(NUM_REGS), .WIDE_MASK(WIDE_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_wide (rd_wide)
  );

  assign spi_miso_oe = cs_act;
endmodule

// File: rtl/spi_ilv_chk.sv
module spi_ilv_chk
  import spi_ilv_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LAG      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              sck_rise,
  input logic              cs_act,
  input logic              mosi_s,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CNT_W-1:0]  frame_last,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input logic              rd_wide
);
  logic [2:0] age;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (age != 3'd7)  age <= age + 1'b1;
  end
  assign settled = age > 3'(LAG);

  // R7
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(spi_cs_n, LAG)) |-> spi_miso_oe);

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(spi_cs_n, LAG)) |-> !spi_miso_oe);

  // R2
  cmd_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && cs_act && bit_cnt < CNT_W'(CMD_BITS)) |=> spi_miso == $past(mosi_s));

  // R5
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bit_cnt > frame_last || !cs_act));

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= ADDR_W'(NUM_REGS)) |-> (rd_data == '0 && !rd_wide));

  // R9
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && cs_act && bit_cnt > frame_last) |=> (!spi_miso && !wr_en));
endmodule

bind spi_ilv_regslave spi_ilv_chk #(.NUM_REGS(NUM_REGS), .LAG(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .sck_rise    (sck_rise),
  .cs_act      (cs_act),
  .mosi_s      (mosi_s),
  .bit_cnt     (bit_cnt),
  .frame_last  (frame_last),
  .wr_en       (wr_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .rd_wide     (rd_wide)
);

// File: tb/spi_ilv_regslave_tb.sv
module spi_ilv_regslave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREG       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model [128];
  bit    exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ilv_regslave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sck     (sck),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe)
  );

  function automatic bit is_wide(logic [6:0] a);
    return (a < NREG) && a[0];
  endfunction

  // R4: word order D15,D7,D14,D6,...; byte order D7..D0
  function automatic bit stream_bit(logic [15:0] v, bit wide, int d);
    if (wide) return (d % 2 == 0) ? v[15 - d/2] : v[7 - (d-1)/2];
    return v[7 - d];
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected output bit per serial clock period
  always @(negedge sck) begin : monitor
    bit    e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(miso === e, t, {15'b0, miso}, {15'b0, e});
      check(miso_oe === 1'b1, "R7", {15'b0, miso_oe}, 16'd1);
    end
  end

  // driver: R1 command = {write flag, address}, MSB first
  task automatic xfer(logic [7:0] cmd, logic [15:0] payload, int nbits, string tag);
    bit          wr   = cmd[7];
    logic [6:0]  a    = cmd[6:0];
    bit          wide = is_wide(a);
    int          dlen = wide ? 16 : 8;
    bit          mo;
    bit          ex;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) begin
        mo = cmd[7-i];
        ex = cmd[7-i];
      end else if (i - 8 < dlen) begin
        mo = wr ? stream_bit(payload, wide, i-8) : 1'b1;
        ex = wr ? 1'b0 : stream_bit(model[a], wide, i-8);
      end else begin
        mo = 1'b1;
        ex = 1'b0;
      end
      exp_q.push_back(ex);
      tag_q.push_back(tag);
      mosi = mo;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
    check(miso_oe === 1'b0, "R7", {15'b0, miso_oe}, 16'd0);
    if (wr && a < NREG && nbits >= 8 + dlen)
      model[a] = wide ? payload : {8'h00, payload[7:0]};
  endtask

  task automatic wr_reg(logic [6:0] a, logic [15:0] v, string tag);
    xfer({1'b1, a}, v, is_wide(a) ? 24 : 16, tag);
  endtask

  task automatic rd_reg(logic [6:0] a, string tag);
    xfer({1'b0, a}, 16'h0, is_wide(a) ? 24 : 16, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 128; i++) model[i] = 16'h0;
    repeat (5) @(negedge clk);
    check(miso_oe === 1'b0, "R7", {15'b0, miso_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(miso_oe === 1'b0 && miso === 1'b0, "R8", {14'b0, miso_oe, miso}, 16'd0);

    for (int a = 0; a < NREG; a++) rd_reg(7'(a), "R8");

    wr_reg(7'd2, 16'h00A5, "R1");
    rd_reg(7'd2, "R3");
    wr_reg(7'd0, 16'h005C, "R1");
    rd_reg(7'd0, "R3");

    wr_reg(7'd3, 16'h1234, "R4");
    rd_reg(7'd3, "R4");
    wr_reg(7'd1, 16'hFF00, "R4");
    rd_reg(7'd1, "R4");
    wr_reg(7'd7, 16'h0F3C, "R4");
    rd_reg(7'd7, "R4");

    xfer({1'b1, 7'd3}, 16'hBEEF, 23, "R5");
    rd_reg(7'd3, "R5");
    xfer({1'b1, 7'd2}, 16'h0011, 12, "R5");
    rd_reg(7'd2, "R5");

    wr_reg(7'h40, 16'h0077, "R6");
    xfer({1'b0, 7'h40}, 16'h0, 16, "R6");
    xfer({1'b0, 7'h09}, 16'h0, 24, "R6");

    xfer({1'b1, 7'd4}, 16'h00C3, 24, "R9");
    rd_reg(7'd4, "R9");
    xfer({1'b0, 7'd2}, 16'h0, 22, "R9");
    rd_reg(7'd5, "R9");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule